// File: doc/BRIEF.md
# Bias Ladder Power-Mode Timer

This block decides which of three internal bias resistor ladders (low, medium or high current) feeds the display bias nodes at each clock of a segment slot, or whether none does. A slot is sixteen display clocks. A pulse on the transition strobe marks a change in the segment or common waveform and starts a new slot. From then on a short high-current burst, the first window, runs for a programmable number of clocks, 0 to 7. The second window covers the rest of the slot, and each window has its own ladder choice. With no fresh strobe, slots repeat every sixteen clocks.

The block also supplies the contrast trim code for the ladder in use. The ladder select codes, the burst length and the trim code are sampled only when a slot starts, so software may rewrite them at any time without disturbing a slot already in progress. A master off input forces all ladders off. The slot counter keeps running while the ladders are off, so the bias returns at the correct slot position once the input is released.

Top module: `bias_ladder_timer`

## Requirements
- R1: After reset and until the first transition strobe, all three ladder enables and the trim output are 0.
- R2: A strobe sampled on a clock edge puts the block at slot position 0 from that edge onward. At positions 0 to N-1 the first-window select is used, and at positions N to 15 the second-window select is used. N is the captured burst code (0 to 7). Code 0 gives the second window for the whole slot.
- R3: Select encoding: 2'b11 enables ladder_en_o[2] (high current), 2'b10 enables ladder_en_o[1] (medium), 2'b01 enables ladder_en_o[0] (low current), and 2'b00 enables no ladder.
- R4: At most one ladder enable is high in any cycle, and a change from one ladder to another takes effect at a single clock edge.
- R5: The burst code, both select codes and the trim code are captured only at a slot start, which is either a strobe or the edge that follows position 15. Changes to these inputs at other times have no effect until the next slot start.
- R6: Without a strobe, the position wraps from 15 to 0 and a new slot begins. A strobe in mid-slot restarts the slot at position 0.
- R7: A strobe that arrives on the same edge as the natural wrap from position 15 produces a single slot start at position 0, with the configuration present on that edge.
- R8: While a ladder is enabled, trim_o equals the captured 3-bit contrast code (0 removes the trim resistance, k gives k/7 of maximum resistance, 7 gives maximum resistance). While no ladder is enabled, trim_o is 0.
- R9: From the first edge on which bias_off_i is sampled high until the first edge on which it is sampled low, all enables and trim_o are 0. The slot position keeps advancing during this time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Display clock, one tick per slot position |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_edge_i | input | 1 | Transition strobe that starts a slot |
| bias_off_i | input | 1 | Master off for all ladders |
| burst_len_i | input | LEN_W (3) | Length of the first window in clocks |
| sel_a_i | input | 2 | Ladder select for the first window |
| sel_b_i | input | 2 | Ladder select for the second window |
| trim_i | input | TRIM_W (3) | Contrast trim code |
| ladder_en_o | output | 3 | Ladder enables: bit 2 high, bit 1 medium, bit 0 low |
| trim_o | output | TRIM_W (3) | Trim code for the active ladder |

## Verification
A transition strobe can land on the same edge as the natural wrap from position 15. In that cycle the counter and the configuration capture must treat the two events as one slot start. The sweep makes this happen on every slot after the first, because each new configuration and its strobe are applied exactly at position 15. The bench also changes all configuration inputs to their bitwise complements right after each slot start. A correct design therefore shows the values captured with the strobe for all sixteen positions, and the bench judges this against its own model of position and captured configuration.

// File: rtl/bias_ladder_pkg.sv
package bias_ladder_pkg;

  localparam int unsigned NUM_LADDERS = 3;

  typedef enum logic [1:0] {
    LADDER_OFF  = 2'b00,
    LADDER_LOW  = 2'b01,
    LADDER_MED  = 2'b10,
    LADDER_HIGH = 2'b11
  } ladder_sel_e;

endpackage

// File: rtl/blt_slot_timer.sv
module blt_slot_timer #(
  parameter int unsigned SLOT_LEN = 16,
  localparam int unsigned CNT_W = $clog2(SLOT_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  output logic             started_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             slot_start_o
);

  localparam int unsigned LAST = SLOT_LEN - 1;

  logic             started_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == CNT_W'(LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      cnt_q     <= '0;
    end else if (edge_i) begin
      started_q <= 1'b1;
      cnt_q     <= '0;
    end else if (started_q) begin
      cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
    end
  end

  // strobe and wrap on the same edge collapse into one start
  assign slot_start_o = edge_i | (started_q & at_last);
  assign started_o    = started_q;
  assign cnt_o        = cnt_q;

endmodule

// File: rtl/blt_cfg_shadow.sv
module blt_cfg_shadow #(
  parameter int unsigned LEN_W  = 3,
  parameter int unsigned TRIM_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [1:0]        sel_a_i,
  input  logic [1:0]        sel_b_i,
  input  logic [TRIM_W-1:0] trim_i,
  output logic [LEN_W-1:0]  len_o,
  output logic [1:0]        sel_a_o,
  output logic [1:0]        sel_b_o,
  output logic [TRIM_W-1:0] trim_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_o   <= '0;
      sel_a_o <= '0;
      sel_b_o <= '0;
      trim_o  <= '0;
    end else if (load_i) begin
      len_o   <= len_i;
      sel_a_o <= sel_a_i;
      sel_b_o <= sel_b_i;
      trim_o  <= trim_i;
    end
  end

endmodule

// File: rtl/blt_ladder_drive.sv
module blt_ladder_drive
  import bias_ladder_pkg::*;
#(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned LEN_W  = 3,
  parameter int unsigned TRIM_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   off_i,
  input  logic                   started_i,
  input  logic [CNT_W-1:0]       cnt_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic [1:0]             sel_a_i,
  input  logic [1:0]             sel_b_i,
  input  logic [TRIM_W-1:0]      trim_i,
  output logic [NUM_LADDERS-1:0] en_o,
  output logic [TRIM_W-1:0]      trim_o
);

  localparam int unsigned CMP_W = (LEN_W > CNT_W) ? LEN_W : CNT_W;

  logic        off_q;
  logic        phase_a;
  logic        live;
  ladder_sel_e sel_cur;

  // off is registered so every enable change lands on a clock edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) off_q <= 1'b0;
    else         off_q <= off_i;
  end

  assign phase_a = (CMP_W'(len_i) > CMP_W'(cnt_i));
  assign sel_cur = ladder_sel_e'(phase_a ? sel_a_i : sel_b_i);
  assign live    = started_i & ~off_q;

  for (genvar i = 0; i < NUM_LADDERS; i++) begin : g_en
    assign en_o[i] = live & (2'(sel_cur) == 2'(i + 1));
  end

  assign trim_o = (live && sel_cur != LADDER_OFF) ? trim_i : '0;

endmodule

// File: rtl/bias_ladder_timer.sv
module bias_ladder_timer
  import bias_ladder_pkg::*;
#(
  parameter int unsigned SLOT_LEN = 16,
  parameter int unsigned LEN_W    = 3,
  parameter int unsigned TRIM_W   = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   seg_edge_i,
  input  logic                   bias_off_i,
  input  logic [LEN_W-1:0]       burst_len_i,
  input  logic [1:0]             sel_a_i,
  input  logic [1:0]             sel_b_i,
  input  logic [TRIM_W-1:0]      trim_i,
  output logic [NUM_LADDERS-1:0] ladder_en_o,
  output logic [TRIM_W-1:0]      trim_o
);

  localparam int unsigned CNT_W = $clog2(SLOT_LEN);

  logic              started;
  logic [CNT_W-1:0]  cnt;
  logic              slot_start;
  logic [LEN_W-1:0]  sh_len;
  logic [1:0]        sh_sel_a;
  logic [1:0]        sh_sel_b;
  logic [TRIM_W-1:0] sh_trim;

  blt_slot_timer #(.SLOT_LEN(SLOT_LEN)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .edge_i       (seg_edge_i),
    .started_o    (started),
    .cnt_o        (cnt),
    .slot_start_o (slot_start)
  );

  blt_cfg_shadow #(.LEN_W(LEN_W), .TRIM_W(TRIM_W)) u_shadow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (slot_start),
    .len_i   (burst_len_i),
    .sel_a_i (sel_a_i),
    .sel_b_i (sel_b_i),
    .trim_i  (trim_i),
    .len_o   (sh_len),
    .sel_a_o (sh_sel_a),
    .sel_b_o (sh_sel_b),
    .trim_o  (sh_trim)
  );

  blt_ladder_drive #(.CNT_W(CNT_W), .LEN_W(LEN_W), .TRIM_W(TRIM_W)) u_drive (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .off_i     (bias_off_i),
    .started_i (started),
    .cnt_i     (cnt),
    .len_i     (sh_len),
    .sel_a_i   (sh_sel_a),
    .sel_b_i   (sh_sel_b),
    .trim_i    (sh_trim),
    .en_o      (ladder_en_o),
    .trim_o    (trim_o)
  );

endmodule

// File: rtl/bias_ladder_timer_chk.sv
module bias_ladder_timer_chk #(
  parameter int unsigned SLOT_LEN = 16,
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned LEN_W    = 3,
  parameter int unsigned TRIM_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              seg_edge_i,
  input logic              bias_off_i,
  input logic [2:0]        ladder_en_o,
  input logic [TRIM_W-1:0] trim_o,
  input logic              started,
  input logic [CNT_W-1:0]  cnt,
  input logic              slot_start,
  input logic [LEN_W-1:0]  sh_len,
  input logic [1:0]        sh_sel_a,
  input logic [1:0]        sh_sel_b,
  input logic [TRIM_W-1:0] sh_trim
);

  localparam int unsigned LAST  = SLOT_LEN - 1;
  localparam int unsigned CMP_W = (LEN_W > CNT_W) ? LEN_W : CNT_W;

  assert_idle_before_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started |-> (ladder_en_o == 3'b000 && trim_o == '0));

  assert_burst_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && !$past(bias_off_i) && CMP_W'(sh_len) > CMP_W'(cnt) && sh_sel_a == 2'b11)
      |-> ladder_en_o == 3'b100);

  assert_single_ladder_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ladder_en_o));

  assert_cfg_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_start |=> ($stable(sh_len) && $stable(sh_sel_a) && $stable(sh_sel_b) && $stable(sh_trim)));

  assert_strobe_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_edge_i |=> cnt == '0);

  assert_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && cnt == CNT_W'(LAST)) |=> cnt == '0);

  assert_trim_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ladder_en_o != 3'b000) |-> trim_o == sh_trim);

  assert_trim_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ladder_en_o == 3'b000) |-> trim_o == '0);

  assert_master_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(bias_off_i) && $past(rst_ni)) |-> (ladder_en_o == 3'b000 && trim_o == '0));

endmodule

bind bias_ladder_timer bias_ladder_timer_chk #(
  .SLOT_LEN (SLOT_LEN),
  .CNT_W    (CNT_W),
  .LEN_W    (LEN_W),
  .TRIM_W   (TRIM_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .seg_edge_i  (seg_edge_i),
  .bias_off_i  (bias_off_i),
  .ladder_en_o (ladder_en_o),
  .trim_o      (trim_o),
  .started     (started),
  .cnt         (cnt),
  .slot_start  (slot_start),
  .sh_len      (sh_len),
  .sh_sel_a    (sh_sel_a),
  .sh_sel_b    (sh_sel_b),
  .sh_trim     (sh_trim)
);

// File: tb/bias_ladder_timer_tb.sv
module bias_ladder_timer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       seg_edge = 1'b0;
  logic       bias_off = 1'b0;
  logic [2:0] burst_len = '0;
  logic [1:0] sel_a = '0;
  logic [1:0] sel_b = '0;
  logic [2:0] trim = '0;
  logic [2:0] ladder_en;
  logic [2:0] trim_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of slot position and captured configuration
  bit         m_started = 1'b0;
  bit         m_off = 1'b0;
  int         m_pos = 0;
  int         m_n = 0;
  logic [1:0] m_a = '0;
  logic [1:0] m_b = '0;
  logic [2:0] m_t = '0;

  always #10 clk = ~clk;

  bias_ladder_timer u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .seg_edge_i  (seg_edge),
    .bias_off_i  (bias_off),
    .burst_len_i (burst_len),
    .sel_a_i     (sel_a),
    .sel_b_i     (sel_b),
    .trim_i      (trim),
    .ladder_en_o (ladder_en),
    .trim_o      (trim_out)
  );

  function automatic logic [2:0] dec(logic [1:0] s);
    case (s)
      2'b11:   return 3'b100;
      2'b10:   return 3'b010;
      2'b01:   return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  task automatic check(string req, logic [2:0] en_e, logic [2:0] tr_e);
    checks++;
    if (ladder_en !== en_e || trim_out !== tr_e) begin
      errors++;
      $display("FAIL %s pos=%0d en=%b trim=%0d expected en=%b trim=%0d",
               req, m_pos, ladder_en, trim_out, en_e, tr_e);
    end
  endtask

  // advance model with the inputs the coming edge sees, then sample
  task automatic step(string req);
    logic [2:0] en_e;
    if (seg_edge) begin
      m_started = 1'b1;
      m_pos = 0;
      m_n = int'(burst_len); m_a = sel_a; m_b = sel_b; m_t = trim;
    end else if (m_started) begin
      if (m_pos == 15) begin
        m_pos = 0;
        m_n = int'(burst_len); m_a = sel_a; m_b = sel_b; m_t = trim;
      end else begin
        m_pos++;
      end
    end
    m_off = bias_off;
    @(negedge clk);
    en_e = (!m_started || m_off) ? 3'b000 : dec((m_pos < m_n) ? m_a : m_b);
    check(req, en_e, (en_e != 3'b000) ? m_t : 3'd0);
  endtask

  task automatic set_cfg(int n, logic [1:0] a, logic [1:0] b, logic [2:0] t);
    burst_len = 3'(n); sel_a = a; sel_b = b; trim = t;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 3'b000, 3'd0);
    rst_n = 1'b1;
    set_cfg(5, 2'b11, 2'b01, 3'd4);
    for (int k = 0; k < 20; k++) step("R1 no strobe yet");

    // sweep: every burst length against every select pair; strobe lands at pos 15 (R7)
    for (int n = 0; n < 8; n++) begin
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b < 4; b++) begin
          set_cfg(n, 2'(a), 2'(b), 3'((n + a * 3 + b) & 7));
          seg_edge = 1'b1;
          for (int j = 0; j < 16; j++) begin
            step("R2 R3 R4 R5 R7 R8");
            if (j == 0) begin
              seg_edge = 1'b0;
              set_cfg(7 - n, ~2'(a), ~2'(b), ~3'((n + a * 3 + b) & 7));
            end
          end
        end
      end
    end

    // free-running slots reload at wrap
    set_cfg(2, 2'b10, 2'b11, 3'd6);
    for (int k = 0; k < 32; k++) step("R6 free run");

    // mid-slot strobe restarts with new configuration
    set_cfg(7, 2'b01, 2'b10, 3'd3);
    for (int k = 0; k < 24; k++) begin
      step("R6 restart");
      seg_edge = (k == 6);
      if (k == 6) set_cfg(4, 2'b11, 2'b00, 3'd1);
    end

    // master off across the burst boundary, counter keeps running
    set_cfg(6, 2'b11, 2'b10, 3'd7);
    seg_edge = 1'b1;
    for (int k = 0; k < 36; k++) begin
      step("R9 master off");
      seg_edge = 1'b0;
      bias_off = (k >= 3 && k <= 7) || (k >= 14 && k <= 18);
    end
    bias_off = 1'b0;
    for (int k = 0; k < 4; k++) step("R9 release");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule